// File: doc/BRIEF.md
# Priority-Managed Block Read Cache

This block lets a processor read a slow, block-oriented backing store as if it were a random-access read-only memory. The processor issues single-word reads on a request port. A read whose block is already held in the cache returns its word one cycle later and never touches the backing store. A read whose block is absent raises a stall and issues one fetch for the whole containing block. The backing store then streams that block's data words in ascending order, followed by its spare-area bytes.

Each block's spare area holds an 8-bit replacement priority, which the controller captures as the block is loaded. The tag store is fully associative over a small number of lines, and every line is compared in parallel. Empty lines are filled first. After that, a new block replaces the resident line with the lowest priority, so blocks marked as hot stay resident and rarely used blocks are the first to leave. Only one miss may be outstanding. The requested word is returned as soon as its beat arrives, even though the stall remains until the spare bytes have been received.

Top module: `nrc_read_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_stall`, `cpu_ready` and `bk_req` are low, and the first read of any block causes a backing fetch.
- R2: A read accepted while `cpu_stall` is low whose block is resident gives `cpu_ready` high in the next cycle only, with the addressed word on `cpu_rdata`, and `bk_req` stays low.
- R3: A read accepted for a non-resident block raises `bk_req` for exactly one cycle, in the cycle after acceptance, with `bk_blk` equal to `cpu_addr >> log2(BLOCK_WORDS)`. `cpu_stall` is high from that cycle until the cycle after the final spare beat.
- R4: During a fill, `cpu_ready` pulses once, in the cycle after the data beat whose index equals the requested offset, and carries that beat's word.
- R5: While `cpu_stall` is high, `cpu_req` is ignored: it causes no further fetch and no extra `cpu_ready`.
- R6: A fill is `BLOCK_WORDS` data beats (offsets 0 upward) followed by `SPARE_BYTES` spare beats, each carrying one byte in `bk_data[7:0]`. The line's priority is the 8-bit unsigned byte of spare beat number `PRIO_IDX` (default 2), and the other bytes are ignored.
- R7: Invalid lines are filled before any valid line is replaced, lowest index first.
- R8: With all lines valid, the victim is the line with the lowest priority, and ties go to the lowest line index.
- R9: No write path exists: a resident line's words read back unchanged until that line is chosen as a victim.
- R10: A block is resident in at most one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request, accepted when `cpu_stall` is low |
| cpu_addr | input | ADDR_W | Word address: block number above the offset bits |
| cpu_stall | output | 1 | High while a fill is in progress; requests are not accepted |
| cpu_ready | output | 1 | One-cycle pulse marking valid `cpu_rdata` |
| cpu_rdata | output | WORD_W | Returned word |
| bk_req | output | 1 | One-cycle block fetch request |
| bk_blk | output | ADDR_W-log2(BLOCK_WORDS) | Block number to fetch |
| bk_valid | input | 1 | Beat valid from the backing store |
| bk_data | input | WORD_W | Beat payload: data word, or a spare byte in bits 7:0 |

## Verification
The checker watches the following on every cycle:
- the one-cycle hit response without a fetch;
- the fetch that follows each accepted miss, and only an accepted miss;
- the single ready pulse while stalled;
- that no block matches in two lines;
- that the victim selector never names a valid line while an invalid one exists, and never names a line whose priority is beaten, or tied at a lower index.

Only the bench's scenarios can show that the right spare byte was captured as priority, that data words survive other fills, that a stray request during a fill leaves no trace, and that the ready pulse lines up with the requested beat under gapped streaming. It observes these through which later reads hit and which miss.

// File: rtl/nrc_pkg.sv
package nrc_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } nrc_state_e;
endpackage

// File: rtl/nrc_tag_match.sv
module nrc_tag_match #(
   parameter int LINES  = 8,
   parameter int BLK_W  = 13,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic [LINES-1:0]            valid,
   input  logic [LINES-1:0][BLK_W-1:0] tags,
   input  logic [BLK_W-1:0]            blk,
   output logic [LINES-1:0]            hit_vec,
   output logic                        hit,
   output logic [LINE_W-1:0]           hit_idx
);
   // parallel comparators, one per line
   for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == blk);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < LINES; i++) begin
         if (hit_vec[i]) hit_idx = LINE_W'(i);
      end
   end
endmodule

// File: rtl/nrc_victim_sel.sv
module nrc_victim_sel #(
   parameter int LINES  = 8,
   parameter int PRIO_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic [LINES-1:0]             valid,
   input  logic [LINES-1:0][PRIO_W-1:0] prio,
   output logic [LINE_W-1:0]            vict_idx
);
   logic              any_free;
   logic [LINE_W-1:0] free_idx;
   logic [LINE_W-1:0] low_idx;
   logic [PRIO_W-1:0] low_val;

   // lowest-index empty line
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            any_free = 1'b1;
            free_idx = LINE_W'(i);
         end
      end
   end

   // lowest priority; strict compare keeps the lower index on ties
   always_comb begin
      low_idx = '0;
      low_val = prio[0];
      for (int i = 1; i < LINES; i++) begin
         if (prio[i] < low_val) begin
            low_val = prio[i];
            low_idx = LINE_W'(i);
         end
      end
   end

   assign vict_idx = any_free ? free_idx : low_idx;
endmodule

// File: rtl/nrc_data_store.sv
module nrc_data_store #(
   parameter int LINES       = 8,
   parameter int BLOCK_WORDS = 8,
   parameter int WORD_W      = 32,
   localparam int LINE_W = $clog2(LINES),
   localparam int OFF_W  = $clog2(BLOCK_WORDS),
   localparam int DEPTH  = LINES * BLOCK_WORDS
) (
   input  logic              clk,
   input  logic              we,
   input  logic [LINE_W-1:0] w_line,
   input  logic [OFF_W-1:0]  w_off,
   input  logic [WORD_W-1:0] w_data,
   input  logic [LINE_W-1:0] r_line,
   input  logic [OFF_W-1:0]  r_off,
   output logic [WORD_W-1:0] r_data
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[{w_line, w_off}] <= w_data;
   end

   assign r_data = mem[{r_line, r_off}];
endmodule

// File: rtl/nrc_read_cache.sv
module nrc_read_cache
   import nrc_pkg::*;
#(
   parameter int CAPACITY_BYTES = 256,
   parameter int LINES          = 8,
   parameter int BLOCK_WORDS    = 8,
   parameter int WORD_W         = 32,
   parameter int ADDR_W         = 16,
   parameter int SPARE_BYTES    = 4,
   parameter int PRIO_IDX       = 2,
   parameter int PRIO_W         = 8,
   localparam int LINE_W = $clog2(LINES),
   localparam int OFF_W  = $clog2(BLOCK_WORDS),
   localparam int BLK_W  = ADDR_W - OFF_W,
   localparam int BEATS  = BLOCK_WORDS + SPARE_BYTES,
   localparam int CNT_W  = $clog2(BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_stall,
   output logic              cpu_ready,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              bk_req,
   output logic [BLK_W-1:0]  bk_blk,
   input  logic              bk_valid,
   input  logic [WORD_W-1:0] bk_data
);
   localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(BLOCK_WORDS);
   localparam logic [CNT_W-1:0] PRIO_BEAT = CNT_W'(BLOCK_WORDS + PRIO_IDX);
   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

   // elaboration-time parameter checks
   if (LINES < 2) begin : g_bad_lines
      $error("nrc_read_cache: LINES must be at least 2");
   end
   if ((1 << OFF_W) != BLOCK_WORDS || BLOCK_WORDS < 2) begin : g_bad_block
      $error("nrc_read_cache: BLOCK_WORDS must be a power of two >= 2");
   end
   if (CAPACITY_BYTES != LINES * BLOCK_WORDS * (WORD_W / 8)) begin : g_bad_cap
      $error("nrc_read_cache: CAPACITY_BYTES disagrees with geometry");
   end
   if (WORD_W % 8 != 0 || WORD_W < PRIO_W) begin : g_bad_word
      $error("nrc_read_cache: WORD_W must be whole bytes and hold a priority");
   end
   if (PRIO_IDX < 0 || PRIO_IDX >= SPARE_BYTES) begin : g_bad_prio
      $error("nrc_read_cache: PRIO_IDX outside spare area");
   end
   if (BLK_W < 1) begin : g_bad_addr
      $error("nrc_read_cache: ADDR_W too small for block size");
   end

   nrc_state_e                   state_q;
   logic [LINES-1:0]             valid_q;
   logic [LINES-1:0][BLK_W-1:0]  tag_q;
   logic [LINES-1:0][PRIO_W-1:0] prio_q;
   logic [LINE_W-1:0]            vict_q;
   logic [OFF_W-1:0]             off_q;
   logic [CNT_W-1:0]             cnt_q;

   logic [BLK_W-1:0]  blk_in;
   logic [OFF_W-1:0]  off_in;
   logic [LINES-1:0]  hit_vec;
   logic              hit;
   logic [LINE_W-1:0] hit_idx;
   logic [LINE_W-1:0] vict_idx;
   logic [WORD_W-1:0] store_rd;
   logic              fill_beat;
   logic              data_beat;

   assign blk_in    = cpu_addr[ADDR_W-1:OFF_W];
   assign off_in    = cpu_addr[OFF_W-1:0];
   assign cpu_stall = (state_q == ST_FILL);
   assign fill_beat = (state_q == ST_FILL) && bk_valid;
   assign data_beat = fill_beat && (cnt_q < DATA_END);

   nrc_tag_match #(.LINES(LINES), .BLK_W(BLK_W)) u_match (
      .valid   (valid_q),
      .tags    (tag_q),
      .blk     (blk_in),
      .hit_vec (hit_vec),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   nrc_victim_sel #(.LINES(LINES), .PRIO_W(PRIO_W)) u_victim (
      .valid    (valid_q),
      .prio     (prio_q),
      .vict_idx (vict_idx)
   );

   nrc_data_store #(.LINES(LINES), .BLOCK_WORDS(BLOCK_WORDS), .WORD_W(WORD_W)) u_store (
      .clk    (clk),
      .we     (data_beat),
      .w_line (vict_q),
      .w_off  (cnt_q[OFF_W-1:0]),
      .w_data (bk_data),
      .r_line (hit_idx),
      .r_off  (off_in),
      .r_data (store_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         valid_q   <= '0;
         tag_q     <= '0;
         prio_q    <= '0;
         vict_q    <= '0;
         off_q     <= '0;
         cnt_q     <= '0;
         bk_req    <= 1'b0;
         bk_blk    <= '0;
         cpu_ready <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_ready <= 1'b0;
         bk_req    <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  if (hit) begin
                     cpu_ready <= 1'b1;
                     cpu_rdata <= store_rd;
                  end else begin
                     state_q           <= ST_FILL;
                     vict_q            <= vict_idx;
                     off_q             <= off_in;
                     cnt_q             <= '0;
                     bk_req            <= 1'b1;
                     bk_blk            <= blk_in;
                     valid_q[vict_idx] <= 1'b0;
                     tag_q[vict_idx]   <= blk_in;
                  end
               end
            end
            ST_FILL: begin
               if (bk_valid) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (data_beat && (cnt_q[OFF_W-1:0] == off_q)) begin
                     cpu_ready <= 1'b1;
                     cpu_rdata <= bk_data;
                  end
                  if (cnt_q == PRIO_BEAT) prio_q[vict_q] <= bk_data[PRIO_W-1:0];
                  if (cnt_q == LAST_BEAT) begin
                     state_q         <= ST_IDLE;
                     valid_q[vict_q] <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nrc_chk.sv
module nrc_chk #(
   parameter int LINES  = 8,
   parameter int PRIO_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cpu_req,
   input logic                        cpu_stall,
   input logic                        cpu_ready,
   input logic                        bk_req,
   input logic                        hit,
   input logic [LINES-1:0]            hit_vec,
   input logic [LINES-1:0]            valid_q,
   input logic [LINES-1:0][PRIO_W-1:0] prio_q,
   input logic [LINE_W-1:0]           vict_idx
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_q == '0 && !cpu_ready && !cpu_stall && !bk_req));

   // R2
   hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_stall && hit) |=> (cpu_ready && !bk_req));

   // R3
   miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_stall && !hit) |=> (bk_req && cpu_stall));

   // R5
   fetch_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bk_req |-> $past(cpu_req && !cpu_stall && !hit));

   // R4
   single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_stall) |=> !cpu_ready);

   // R10
   unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R7
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&valid_q) |-> !valid_q[vict_idx]);

   for (genvar g = 0; g < LINES; g++) begin : g_prio
      // R8
      lowest_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&valid_q) |-> (prio_q[g] >= prio_q[vict_idx]));
      // R8
      tie_low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((&valid_q) && (LINE_W'(g) < vict_idx)) |-> (prio_q[g] > prio_q[vict_idx]));
   end
endmodule

bind nrc_read_cache nrc_chk #(.LINES(LINES), .PRIO_W(PRIO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_stall (cpu_stall),
   .cpu_ready (cpu_ready),
   .bk_req    (bk_req),
   .hit       (hit),
   .hit_vec   (hit_vec),
   .valid_q   (valid_q),
   .prio_q    (prio_q),
   .vict_idx  (vict_idx)
);

// File: tb/nrc_read_cache_tb.sv
`timescale 1ns/1ps
module nrc_read_cache_tb;
   localparam int LINES       = 8;
   localparam int BLOCK_WORDS = 8;
   localparam int WORD_W      = 32;
   localparam int ADDR_W      = 16;
   localparam int SPARE_BYTES = 4;
   localparam int PRIO_IDX    = 2;
   localparam int BLK_W       = ADDR_W - 3;
   localparam int BEATS       = BLOCK_WORDS + SPARE_BYTES;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic              cpu_stall;
   logic              cpu_ready;
   logic [WORD_W-1:0] cpu_rdata;
   logic              bk_req;
   logic [BLK_W-1:0]  bk_blk;
   logic              bk_valid = 1'b0;
   logic [WORD_W-1:0] bk_data = '0;

   nrc_read_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_stall(cpu_stall), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bk_req(bk_req), .bk_blk(bk_blk), .bk_valid(bk_valid), .bk_data(bk_data)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errs = 0;
   int checks = 0;
   int ready_cnt = 0;
   int bkreq_cnt = 0;
   int ready_cyc = 0;
   logic [WORD_W-1:0] last_rdata = '0;
   logic [BLK_W-1:0]  last_blk = '0;

   always @(negedge clk) begin
      if (cpu_ready) begin
         ready_cnt  = ready_cnt + 1;
         ready_cyc  = cyc;
         last_rdata = cpu_rdata;
      end
      if (bk_req) begin
         bkreq_cnt = bkreq_cnt + 1;
         last_blk  = bk_blk;
      end
   end

   always @(posedge clk) begin
      if (cyc == 20000) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   function automatic logic [WORD_W-1:0] exp_word(input int blk, input int off);
      return 32'h5A00_0000 | (WORD_W'(blk) << 8) | WORD_W'(off);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // streams one block; returns the cycle at which the requested offset beat was driven
   task automatic serve_block(input int blk, input int prio, input int off,
                              input bit gap, input bit stray, input string req,
                              output int beat_cyc);
      beat_cyc = -1;
      for (int i = 0; i < BEATS; i++) begin
         if (gap && i == 3) begin
            bk_valid = 1'b0;
            @(negedge clk);
         end
         bk_valid = 1'b1;
         if (i < BLOCK_WORDS) bk_data = exp_word(blk, i);
         else if (i - BLOCK_WORDS == PRIO_IDX) bk_data = {24'hFEDCBA, 8'(prio)};
         else bk_data = {24'h123456, 8'h00};
         if (i == off) beat_cyc = cyc;
         if (i == 1) chk(cpu_stall == 1'b1, req, "stall mid-fill", 32'(cpu_stall), 32'd1);
         if (stray && i == 2) begin
            cpu_req  = 1'b1;
            cpu_addr = ADDR_W'(200 * BLOCK_WORDS + 1);
         end else begin
            cpu_req = 1'b0;
         end
         @(negedge clk);
      end
      bk_valid = 1'b0;
      cpu_req  = 1'b0;
   endtask

   task automatic rd_miss(input int blk, input int off, input int prio,
                          input bit gap, input bit stray, input string req);
      int r0, b0, bc;
      r0 = ready_cnt;
      b0 = bkreq_cnt;
      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = ADDR_W'(blk * BLOCK_WORDS + off);
      @(negedge clk);
      cpu_req = 1'b0;
      @(negedge clk);
      chk(bkreq_cnt - b0 == 1, req, "fetch issued on miss", 32'(bkreq_cnt - b0), 32'd1);
      chk(last_blk == BLK_W'(blk), req, "fetched block number", 32'(last_blk), 32'(blk));
      if (bkreq_cnt - b0 == 1) begin
         serve_block(blk, prio, off, gap, stray, req, bc);
         chk(cpu_stall == 1'b0, req, "stall released after spare", 32'(cpu_stall), 32'd0);
         @(negedge clk);
         @(negedge clk);
         chk(ready_cnt - r0 == 1, req, "ready pulses per fill", 32'(ready_cnt - r0), 32'd1);
         chk(ready_cyc == bc + 1, req, "ready timing", 32'(ready_cyc), 32'(bc + 1));
         chk(last_rdata == exp_word(blk, off), req, "fill data", last_rdata, exp_word(blk, off));
         chk(bkreq_cnt - b0 == 1, req, "no extra fetch", 32'(bkreq_cnt - b0), 32'd1);
      end
   endtask

   task automatic rd_hit(input int blk, input int off, input string req);
      int r0, b0, c, bc;
      r0 = ready_cnt;
      b0 = bkreq_cnt;
      @(negedge clk);
      c = cyc;
      cpu_req  = 1'b1;
      cpu_addr = ADDR_W'(blk * BLOCK_WORDS + off);
      @(negedge clk);
      cpu_req = 1'b0;
      @(negedge clk);
      chk(bkreq_cnt == b0, req, "no fetch on hit", 32'(bkreq_cnt - b0), 32'd0);
      if (bkreq_cnt != b0) begin
         serve_block(blk, 0, off, 1'b0, 1'b0, req, bc);
         @(negedge clk);
      end else begin
         chk(ready_cnt - r0 == 1, req, "hit ready count", 32'(ready_cnt - r0), 32'd1);
         chk(ready_cyc == c + 1, req, "hit latency", 32'(ready_cyc), 32'(c + 1));
         chk(last_rdata == exp_word(blk, off), req, "hit data", last_rdata, exp_word(blk, off));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cpu_stall == 1'b0, "R1", "stall in reset", 32'(cpu_stall), 32'd0);
      chk(cpu_ready == 1'b0, "R1", "ready in reset", 32'(cpu_ready), 32'd0);
      chk(bk_req == 1'b0, "R1", "fetch in reset", 32'(bk_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_cold_fill();
      rd_miss(0, 5, 50, 1'b0, 1'b0, "R1");
      rd_miss(1, 0, 20, 1'b1, 1'b0, "R4");
      rd_miss(2, 7, 90, 1'b0, 1'b1, "R5");
      rd_miss(3, 3, 20, 1'b0, 1'b0, "R3");
      rd_miss(4, 1, 70, 1'b1, 1'b0, "R4");
      rd_miss(5, 6, 60, 1'b0, 1'b0, "R3");
      rd_miss(6, 2, 80, 1'b0, 1'b1, "R5");
      rd_miss(7, 4, 40, 1'b0, 1'b0, "R6");
   endtask

   task automatic t_all_resident();
      for (int b = 0; b < 8; b++) rd_hit(b, (b * 3) % BLOCK_WORDS, "R7");
      rd_hit(2, 0, "R2");
      rd_hit(2, 7, "R2");
   endtask

   task automatic t_priority_evict();
      // lines 1 and 3 tie at 20: line 1 (block 1) must go
      rd_miss(8, 7, 100, 1'b0, 1'b0, "R3");
      rd_hit(3, 3, "R8");
      rd_hit(0, 5, "R6");
      rd_hit(8, 0, "R10");
      // block 3 (prio 20) is now lowest
      rd_miss(1, 1, 10, 1'b0, 1'b0, "R8");
      rd_hit(1, 6, "R9");
      // block 1 (prio 10) is now lowest
      rd_miss(3, 2, 30, 1'b1, 1'b0, "R8");
      rd_hit(7, 4, "R9");
      rd_hit(2, 7, "R9");
      // block 3 (prio 30) is now lowest; block 7 (prio 40) must survive
      rd_miss(9, 0, 55, 1'b0, 1'b0, "R8");
      rd_hit(7, 1, "R6");
   endtask

   initial begin
      t_reset();
      t_cold_fill();
      t_all_resident();
      t_priority_evict();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule